// File: doc/BRIEF.md
# Seven-Slot Five-Lane Serial Word Deserializer

This block turns five serial data lanes and one forwarded clock lane back into a 35-bit parallel word per pixel period. It runs on a bit clock at seven times the pixel rate and samples every lane once per bit time. The bit in which the sampled clock lane goes from 0 to 1 opens a frame. Each frame carries seven bits per lane in a fixed rotated order, and the block puts them back into their parallel positions. It also rebuilds a pixel-rate output clock whose active edge is chosen by an edge-select pin.

Three pins control the outputs. They can be enabled, held low (power-down or the reserved pin), or released to high impedance. The outputs also stay low until the framer has seen a steady frame phase for several frames in a row. The recovered words form an output stream marked by a one-cycle valid pulse. The link is source-timed, so this stream has no ready input and cannot push back: a consumer must accept every word in the cycle its valid pulse appears. The next word replaces it seven cycles later.

Top module: `serial7_rx`

## Requirements
- R1: Lane L (lane A is `data_lanes[0]` through lane E at `data_lanes[4]`) delivers its bit n on `par_out[7*L+n]`, so the five lanes fill all 35 outputs.
- R2: Within a frame, slot 0 is the sample in which the clock lane reads 1 after reading 0 in the previous sample. Slot 0 carries bit 1 and slot 1 carries bit 0. Slots 2, 3, 4, 5 and 6 carry bits 6, 5, 4, 3 and 2.
- R3: Every 0-to-1 transition of the sampled clock lane realigns the slot counter so that its sample is slot 0. After a phase jump, words are again recovered correctly once lock returns.
- R4: `locked` rises only after four consecutive frames whose transition falls exactly where slot 0 was predicted. The first transition after reset only sets the phase, so `locked` becomes 1 during the fifth frame.
- R5: A frame whose predicted slot 0 has no transition, or whose transition arrives elsewhere, is a mismatch. `locked` falls after two consecutive mismatches, and a single mismatch followed by a good frame leaves it set.
- R6: While `locked` is 0, with `out_en` high, all data outputs and `pix_clk_out` are driven low and `word_vld` is 0.
- R7: `word_vld` pulses for one cycle every seven cycles. The pulse comes one cycle after the slot-6 sample is registered, and `par_out` shows the newly completed word in that same cycle.
- R8: The rebuilt clock is high for 4 of every 7 cycles when `edge_rise` is 1 and is inverted when it is 0. In both modes, the active edge (rising or falling, respectively) comes 3 cycles after each `word_vld` pulse, and `par_out` is unchanged at that edge.
- R9: With `out_en` low, all 35 data outputs and `pix_clk_out` are released to high impedance from the next cycle, whatever the other controls are.
- R10: With `pwr_on` low and `out_en` high, all data outputs and `pix_clk_out` are driven low from the next cycle, and `word_vld` is 0.
- R11: With `rsv` high and `out_en` high, the outputs behave as under R10. `rsv` must be low for normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, seven cycles per pixel period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High for operation, low forces outputs low |
| out_en | input | 1 | High drives outputs, low releases them to high impedance |
| edge_rise | input | 1 | 1: data valid at rising edge of `pix_clk_out`; 0: at falling edge |
| rsv | input | 1 | Reserved, must be low; high forces outputs low |
| clk_lane | input | 1 | Sampled forwarded clock lane |
| data_lanes | input | 5 | Sampled serial data lanes A (bit 0) to E (bit 4) |
| par_out | output | 35 | Recovered parallel word, tri-state |
| pix_clk_out | output | 1 | Rebuilt pixel clock, tri-state |
| word_vld | output | 1 | One-cycle pulse per recovered word, no back-pressure |
| locked | output | 1 | Frame phase is stable |

## Verification
Lanes are sampled at one clock edge, and recovery and lock act on the edge after that. The valid pulse and the new word therefore appear one cycle after the slot-6 sample is captured, and `locked` changes one cycle after the slot-0 sample of the deciding frame. The active clock edge follows the valid pulse by three cycles, and control pin changes reach the outputs one cycle later. The bench keeps a cycle counter from each observed valid pulse and checks the active edge when that counter reaches 3. It compares against the last word it serialised, and it reads `locked` only after the whole frame that decides it has been sent. High impedance is seen at the bench as pulled-up nets reading all ones.

// File: rtl/serial7_pkg.sv
package serial7_pkg;
  localparam int SLOTS    = 7;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int HI_FIRST = 2;
  localparam int HI_LEN   = 4;

  typedef logic [SLOT_W-1:0] slot_t;

  // Rotated order on the wire: slot k carries bit slot_bit(k)
  function automatic int slot_bit(input int k);
    if (k == 0)      return 1;
    else if (k == 1) return 0;
    else             return SLOTS + 1 - k;
  endfunction
endpackage

// File: rtl/s7_lane.sv
module s7_lane
  import serial7_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             capture,
  output logic [SLOTS-1:0] word_o
);
  logic [SLOTS-2:0] hist_q;   // hist_q[0] holds the newest older sample
  logic [SLOTS-1:0] by_slot;
  logic [SLOTS-1:0] ordered;
  logic [SLOTS-1:0] word_q;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    if (k == SLOTS - 1) begin : g_now
      assign by_slot[k] = din;
    end else begin : g_old
      assign by_slot[k] = hist_q[SLOTS-2-k];
    end
    assign ordered[slot_bit(k)] = by_slot[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      word_q <= '0;
    end else begin
      hist_q <= {hist_q[SLOTS-3:0], din};
      if (capture) word_q <= ordered;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/s7_framer.sv
module s7_framer
  import serial7_pkg::*;
#(
  parameter int LOCK_RUN = 4,
  parameter int LOSS_RUN = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ck_smp,
  output logic  slot_valid,
  output slot_t slot_cur,
  output logic  locked
);
  localparam int GW = $clog2(LOCK_RUN + 1);
  localparam int MW = $clog2(LOSS_RUN + 1);

  logic          prev_q, seen_q, lock_q;
  slot_t         slot_q;
  logic [GW-1:0] good_q;
  logic [MW-1:0] miss_q;
  logic          rise_w, check_w, good_w;

  assign rise_w     = ck_smp & ~prev_q;
  assign slot_cur   = rise_w ? '0 : slot_q;
  assign slot_valid = seen_q | rise_w;
  assign check_w    = seen_q & (rise_w | (slot_q == '0));
  assign good_w     = rise_w & (slot_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      slot_q <= '0;
      good_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
    end else begin
      prev_q <= ck_smp;
      seen_q <= slot_valid;
      slot_q <= (slot_cur == slot_t'(SLOTS - 1)) ? '0 : slot_cur + 1'b1;
      if (check_w) begin
        if (good_w) begin
          miss_q <= '0;
          if (good_q != GW'(LOCK_RUN)) good_q <= good_q + 1'b1;
          if (good_q >= GW'(LOCK_RUN - 1)) lock_q <= 1'b1;
        end else begin
          good_q <= '0;
          if (miss_q >= MW'(LOSS_RUN - 1)) begin
            miss_q <= '0;
            lock_q <= 1'b0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end
    end
  end

  assign locked = lock_q;

  AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(check_w && good_w)); // R4
  AST_UNLOCK_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(check_w && !good_w)); // R5
endmodule

// File: rtl/s7_outstage.sv
module s7_outstage
  import serial7_pkg::*;
#(
  parameter int W = 35
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_on,
  input  logic         out_en,
  input  logic         edge_rise,
  input  logic         rsv,
  input  logic         locked,
  input  logic         slot_valid,
  input  slot_t        slot_cur,
  input  logic         capture,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] data_o,
  output logic         pclk_o,
  output logic         vld_o,
  output logic [W:0]   drive_o
);
  logic       pwr_q, edge_q, rsv_q, ck_q, vld_q;
  logic [W:0] drive_q;
  logic       gate_w, hi_w;

  assign hi_w = slot_valid && (slot_cur >= slot_t'(HI_FIRST))
                && (slot_cur < slot_t'(HI_FIRST + HI_LEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      edge_q  <= 1'b1;
      rsv_q   <= 1'b0;
      ck_q    <= 1'b0;
      vld_q   <= 1'b0;
      drive_q <= '0;
    end else begin
      pwr_q   <= pwr_on;
      edge_q  <= edge_rise;
      rsv_q   <= rsv;
      ck_q    <= hi_w;
      vld_q   <= capture;
      drive_q <= {(W+1){out_en}};
    end
  end

  assign gate_w  = pwr_q & ~rsv_q & locked;
  assign data_o  = gate_w ? word_i : '0;
  assign pclk_o  = gate_w & (edge_q ? ck_q : ~ck_q);
  assign vld_o   = gate_w & vld_q;
  assign drive_o = drive_q;

  AST_CLK_IDLE_AT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && edge_q) |-> !pclk_o); // R8
endmodule

// File: rtl/serial7_rx.sv
module serial7_rx
  import serial7_pkg::*;
#(
  parameter int LANES    = 5,
  parameter int LOCK_RUN = 4,
  parameter int LOSS_RUN = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_on,
  input  logic                   out_en,
  input  logic                   edge_rise,
  input  logic                   rsv,
  input  logic                   clk_lane,
  input  logic [LANES-1:0]       data_lanes,
  output wire  [LANES*SLOTS-1:0] par_out,
  output wire                    pix_clk_out,
  output logic                   word_vld,
  output logic                   locked
);
  localparam int W = LANES * SLOTS;

  logic             ck_smp;
  logic [LANES-1:0] dat_smp;
  logic             slot_valid, capture;
  slot_t            slot_cur;
  logic [W-1:0]     word_w, data_w;
  logic             pclk_w;
  logic [W:0]       drive_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_smp  <= 1'b0;
      dat_smp <= '0;
    end else begin
      ck_smp  <= clk_lane;
      dat_smp <= data_lanes;
    end
  end

  s7_framer #(.LOCK_RUN(LOCK_RUN), .LOSS_RUN(LOSS_RUN)) u_framer (
    .clk(clk), .rst_n(rst_n), .ck_smp(ck_smp),
    .slot_valid(slot_valid), .slot_cur(slot_cur), .locked(locked)
  );

  assign capture = slot_valid && (slot_cur == slot_t'(SLOTS - 1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    s7_lane u_lane (
      .clk(clk), .rst_n(rst_n), .din(dat_smp[l]), .capture(capture),
      .word_o(word_w[l*SLOTS +: SLOTS])
    );
  end

  s7_outstage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
    .edge_rise(edge_rise), .rsv(rsv), .locked(locked),
    .slot_valid(slot_valid), .slot_cur(slot_cur), .capture(capture),
    .word_i(word_w), .data_o(data_w), .pclk_o(pclk_w), .vld_o(word_vld),
    .drive_o(drive_w)
  );

  for (genvar i = 0; i < W; i++) begin : g_tri
    assign par_out[i] = drive_w[i] ? data_w[i] : 1'bz;
  end
  assign pix_clk_out = drive_w[W] ? pclk_w : 1'bz;

  AST_PWRDN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on && out_en) |=> (par_out == '0 && !pix_clk_out)); // R10
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld); // R7
  AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> locked); // R6
endmodule

// File: tb/serial7_rx_tb.sv
module serial7_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_on = 1'b1, out_en = 1'b1, edge_rise = 1'b1, rsv = 1'b0;
  logic       clk_lane = 1'b0;
  logic [4:0] data_lanes = '0;
  tri1 [34:0] par_w;
  tri1        pix_w;
  logic       word_vld, locked;

  always #10 clk = ~clk;

  serial7_rx dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
    .edge_rise(edge_rise), .rsv(rsv), .clk_lane(clk_lane),
    .data_lanes(data_lanes), .par_out(par_w), .pix_clk_out(pix_w),
    .word_vld(word_vld), .locked(locked)
  );

  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  int          order [7] = '{1, 0, 6, 5, 4, 3, 2};
  logic [34:0] last_sent = '0;
  int          settled = 0, run = 0, since = 0;
  bit          saw_vld = 0;
  logic        prev_pix = 1'b0;
  logic [6:0]  hist = '0;

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic set_ctrl(input logic p, input logic o, input logic e, input logic r);
    pwr_on = p; out_en = o; edge_rise = e; rsv = r;
    settled = 0; run = 0; saw_vld = 0;
  endtask

  // per-cycle reference checks, called away from the active edge
  task automatic observe();
    bit normal, active;
    settled++;
    hist = {hist[5:0], pix_w};
    normal = out_en && pwr_on && !rsv && locked;
    if (normal) run++; else begin run = 0; saw_vld = 0; end
    if (!out_en) begin
      check("R9 data hi-Z", {1'b0, par_w}, {1'b0, {35{1'b1}}});
      check("R9 clock hi-Z", {35'd0, pix_w}, 36'd1);
    end else if (!pwr_on || rsv) begin
      check(rsv ? "R11 data low" : "R10 data low", {1'b0, par_w}, 36'd0);
      check("R10 R11 clock/valid low", {34'd0, pix_w, word_vld}, 36'd0);
    end else if (!locked) begin
      check("R6 data low", {1'b0, par_w}, 36'd0);
      check("R6 clock/valid low", {34'd0, pix_w, word_vld}, 36'd0);
    end else begin
      if (word_vld) begin
        check("R7 R2 word on valid", {1'b0, par_w}, {1'b0, last_sent});
        if (saw_vld) check("R7 valid spacing", 36'(since + 1), 36'd7);
        if (run >= 8) check("R8 clock duty", 36'($countones(hist)), edge_rise ? 36'd4 : 36'd3);
        since = 0;
        saw_vld = 1;
      end else begin
        since++;
        active = edge_rise ? (pix_w && !prev_pix) : (!pix_w && prev_pix);
        if (active && saw_vld && run >= 2) begin
          check("R8 active edge timing", 36'(since), 36'd3);
          check("R1 R2 word at active edge", {1'b0, par_w}, {1'b0, last_sent});
        end
      end
    end
    prev_pix = pix_w;
  endtask

  task automatic step(input logic ck, input logic [4:0] d);
    @(negedge clk);
    observe();
    clk_lane = ck;
    data_lanes = d;
  endtask

  task automatic send_frame(input logic [34:0] w, input bit with_ck);
    for (int s = 0; s < 7; s++) begin
      logic [4:0] d;
      for (int l = 0; l < 5; l++) d[l] = w[l*7 + order[s]];
      step(with_ck ? (s < 4) : 1'b0, d);
      if (s == 6) last_sent = w;
    end
  endtask

  function automatic logic [34:0] rnd35();
    return {$urandom, $urandom};
  endfunction

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) send_frame(rnd35(), 1'b1);
  endtask

  initial begin : wd
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : main
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 5'd0);
    check("R4 reset unlocked", {35'd0, locked}, 36'd0);
    // R4: four good frames after the phase-setting one
    send_frame(35'h0_0000_0001, 1'b1);
    send_frame(35'h7_FFFF_FFFF, 1'b1);
    frames(2);
    check("R4 not yet locked", {35'd0, locked}, 36'd0);
    frames(1);
    check("R4 locked in fifth frame", {35'd0, locked}, 36'd1);
    // R1 R2: walking bits and random words
    for (int b = 0; b < 35; b += 5) send_frame(35'd1 << b, 1'b1);
    frames(6);
    // R8: falling-edge mode
    set_ctrl(1'b1, 1'b1, 1'b0, 1'b0);
    frames(8);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    frames(3);
    // R10 power-down, R11 reserved pin
    set_ctrl(1'b0, 1'b1, 1'b1, 1'b0);
    frames(3);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    frames(2);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b1);
    frames(2);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    frames(2);
    // R9 release, with power-down and with normal run
    set_ctrl(1'b0, 1'b0, 1'b1, 1'b0);
    frames(2);
    set_ctrl(1'b1, 1'b0, 1'b1, 1'b0);
    frames(2);
    set_ctrl(1'b1, 1'b1, 1'b1, 1'b0);
    frames(3);
    // R5 single mismatch keeps lock
    send_frame(rnd35(), 1'b0);
    check("R5 lock after one miss", {35'd0, locked}, 36'd1);
    frames(1);
    check("R5 lock after recovery", {35'd0, locked}, 36'd1);
    // R5 two mismatches lose lock, four good regain it
    send_frame(rnd35(), 1'b0);
    check("R5 lock after first miss", {35'd0, locked}, 36'd1);
    send_frame(rnd35(), 1'b0);
    check("R5 lost after second miss", {35'd0, locked}, 36'd0);
    frames(3);
    check("R5 still unlocked", {35'd0, locked}, 36'd0);
    frames(1);
    check("R5 relocked", {35'd0, locked}, 36'd1);
    frames(2);
    // R3 phase jump by one bit time
    step(1'b0, 5'd0);
    frames(1);
    check("R3 unlocked after jump", {35'd0, locked}, 36'd0);
    frames(3);
    check("R3 still unlocked", {35'd0, locked}, 36'd0);
    frames(1);
    check("R3 relocked at new phase", {35'd0, locked}, 36'd1);
    frames(5);
    finish_run();
  end
endmodule